// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general registers of a 32-bit processor core. Sixteen logical registers are visible at any moment, and the current processor mode selects which physical copies sit behind them. The fast-interrupt mode has private copies of registers 8 to 14. Every other exception mode has private copies of only the stack pointer (13) and the link register (14). User and system modes share a single bank. Registers 0 to 7 are common to all modes. In total there are thirty physical general registers plus the program counter.

Logical register 15 is the program counter. Both read ports return it as the current instruction address plus 8. A write to it redirects fetch, and a step input advances it by one word. A separate exception-entry port writes a return address into the link register of a target mode, whatever the current mode is. Two combinational read ports and one clocked write port serve the pipeline's operand and result paths.

Top module: `rbf_banked_regfile`

## Requirements
- R1: Mode codes are 5'b10000 user, 5'b10001 fast interrupt, 5'b10010 interrupt, 5'b10011 supervisor, 5'b10111 abort, 5'b11011 undefined and 5'b11111 system. Any other code is banked exactly like user mode.
- R2: Logical registers 0 to 7 are one physical set shared by every mode. A write made in one mode is read back in every other mode.
- R3: In fast-interrupt mode, logical registers 8 to 12 select private copies. In every other mode they select the shared copies, so writes made in one group do not disturb the other.
- R4: Supervisor, abort, undefined, interrupt and fast-interrupt modes each have their own registers 13 and 14. User and system modes share one pair.
- R5: Reading logical register 15 on either read port returns the current fetch address plus 8.
- R6: A write to logical register 15 loads the PC with the written value, visible on the fetch-address output after the clock edge. It takes priority over a step in the same cycle.
- R7: With step high and no register 15 write, the PC advances by 4 per cycle. With step low and no write, it holds.
- R8: Exception entry writes the return address into register 14 of the target mode's bank only. If it collides with a port write to the same physical register, the exception value wins.
- R9: When a read port addresses the register being written in the same cycle, it returns the old value. The new value appears after the clock edge.
- R10: After reset, every general register reads 0 and the fetch address equals the RESET_PC parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 5 | Current processor mode code |
| rd_a_idx_i | input | 4 | Logical index, read port A |
| rd_a_data_o | output | DATA_W | Read data, port A |
| rd_b_idx_i | input | 4 | Logical index, read port B |
| rd_b_data_o | output | DATA_W | Read data, port B |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Logical index of the write |
| wr_data_i | input | DATA_W | Write data |
| step_i | input | 1 | Advance the PC by 4 |
| exc_en_i | input | 1 | Exception entry strobe |
| exc_mode_i | input | 5 | Target mode of the exception |
| exc_ret_i | input | DATA_W | Return address for the target link register |
| fetch_addr_o | output | DATA_W | Current instruction address |

## Verification
The bench builds the block with DATA_W at 32 and RESET_PC at 32'h100. A non-zero reset address shows that the parameter reaches the PC, and it keeps the plus-8 read of register 15 from being confused with a zero register. Each of the six banks gets its own stack-pointer value, and reads in every mode confirm the banking. The overlapping cases are driven on purpose: a register 15 write together with a step, an exception entry together with a port write to the same link register, and a read together with a write to the same register.

// File: rtl/rbf_pkg.sv
package rbf_pkg;
    localparam int LIDX_W    = 4;
    localparam int PHYS_REGS = 30;
    localparam int PIDX_W    = $clog2(PHYS_REGS);
    localparam int MODE_W    = 5;

    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

    // physical slots: 0..14 shared, 15..19 fast r8-r12, then pairs of r13/r14
    localparam int FIQ_HI_BASE = 15;
    localparam int FIQ_SP_BASE = 20;
    localparam int IRQ_SP_BASE = 22;
    localparam int SVC_SP_BASE = 24;
    localparam int ABT_SP_BASE = 26;
    localparam int UND_SP_BASE = 28;

    typedef enum logic [2:0] {
        BANK_USR, BANK_FIQ, BANK_IRQ, BANK_SVC, BANK_ABT, BANK_UND
    } bank_e;

    function automatic bank_e mode_to_bank(input logic [MODE_W-1:0] m);
        case (m)
            MODE_FIQ: return BANK_FIQ;
            MODE_IRQ: return BANK_IRQ;
            MODE_SVC: return BANK_SVC;
            MODE_ABT: return BANK_ABT;
            MODE_UND: return BANK_UND;
            default:  return BANK_USR;
        endcase
    endfunction
endpackage

// File: rtl/rbf_mode_map.sv
module rbf_mode_map
    import rbf_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic [LIDX_W-1:0] lidx_i,
    output logic [PIDX_W-1:0] pidx_o,
    output logic              is_pc_o
);
    bank_e bank;
    int    slot;

    always_comb begin
        bank    = mode_to_bank(mode_i);
        is_pc_o = (lidx_i == 4'd15);
        slot    = int'(lidx_i);
        if (lidx_i >= 4'd8 && lidx_i <= 4'd12) begin
            if (bank == BANK_FIQ) slot = FIQ_HI_BASE + int'(lidx_i) - 8;
        end else if (lidx_i == 4'd13 || lidx_i == 4'd14) begin
            case (bank)
                BANK_FIQ: slot = FIQ_SP_BASE + int'(lidx_i) - 13;
                BANK_IRQ: slot = IRQ_SP_BASE + int'(lidx_i) - 13;
                BANK_SVC: slot = SVC_SP_BASE + int'(lidx_i) - 13;
                BANK_ABT: slot = ABT_SP_BASE + int'(lidx_i) - 13;
                BANK_UND: slot = UND_SP_BASE + int'(lidx_i) - 13;
                default:  slot = int'(lidx_i);
            endcase
        end else if (is_pc_o) begin
            slot = 0;
        end
        pidx_o = PIDX_W'(slot);
    end
endmodule

// File: rtl/rbf_regs.sv
module rbf_regs
    import rbf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [PIDX_W-1:0] wr_pidx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              exc_en_i,
    input  logic [PIDX_W-1:0] exc_pidx_i,
    input  logic [DATA_W-1:0] exc_data_i,
    input  logic [PIDX_W-1:0] rd_a_pidx_i,
    input  logic [PIDX_W-1:0] rd_b_pidx_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    output logic [DATA_W-1:0] rd_b_data_o
);
    typedef struct packed {
        logic [PHYS_REGS-1:0][DATA_W-1:0] r;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i)  regs_d.r[wr_pidx_i]  = wr_data_i;
        if (exc_en_i) regs_d.r[exc_pidx_i] = exc_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign rd_a_data_o = regs_q.r[rd_a_pidx_i];
    assign rd_b_data_o = regs_q.r[rd_b_pidx_i];

    // R8
    exc_lr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_en_i |=> regs_q.r[$past(exc_pidx_i)] == $past(exc_data_i));

    // R9
    port_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !(exc_en_i && exc_pidx_i == wr_pidx_i))
        |=> regs_q.r[$past(wr_pidx_i)] == $past(wr_data_i));
endmodule

// File: rtl/rbf_pc.sv
module rbf_pc #(
    parameter int                DATA_W   = 32,
    parameter logic [DATA_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic              step_i,
    output logic [DATA_W-1:0] pc_o
);
    localparam logic [DATA_W-1:0] WORD_BYTES = DATA_W'(4);

    typedef struct packed {
        logic [DATA_W-1:0] pc;
    } pc_state_t;

    pc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i)      st_d.pc = load_val_i;
        else if (step_i) st_d.pc = st_q.pc + WORD_BYTES;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.pc <= RESET_PC;
        else        st_q    <= st_d;
    end

    assign pc_o = st_q.pc;

    // R6
    pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> pc_o == $past(load_val_i));

    // R7
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> pc_o == $past(pc_o) + WORD_BYTES);

    // R7
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_i) |=> $stable(pc_o));
endmodule

// File: rtl/rbf_banked_regfile.sv
module rbf_banked_regfile
    import rbf_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter logic [DATA_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    input  logic [3:0]        rd_a_idx_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [3:0]        rd_b_idx_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [3:0]        wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              step_i,
    input  logic              exc_en_i,
    input  logic [4:0]        exc_mode_i,
    input  logic [DATA_W-1:0] exc_ret_i,
    output logic [DATA_W-1:0] fetch_addr_o
);
    localparam logic [DATA_W-1:0] PC_READ_OFS = DATA_W'(8);
    localparam logic [LIDX_W-1:0] LR_IDX      = LIDX_W'(14);

    logic [PIDX_W-1:0] a_pidx, b_pidx, w_pidx, x_pidx;
    logic              a_pc, b_pc, w_pc, x_pc;
    logic [DATA_W-1:0] a_reg, b_reg, pc_q, pc_read;

    rbf_mode_map map_a_i (.mode_i(mode_i),     .lidx_i(rd_a_idx_i), .pidx_o(a_pidx), .is_pc_o(a_pc));
    rbf_mode_map map_b_i (.mode_i(mode_i),     .lidx_i(rd_b_idx_i), .pidx_o(b_pidx), .is_pc_o(b_pc));
    rbf_mode_map map_w_i (.mode_i(mode_i),     .lidx_i(wr_idx_i),   .pidx_o(w_pidx), .is_pc_o(w_pc));
    rbf_mode_map map_x_i (.mode_i(exc_mode_i), .lidx_i(LR_IDX),     .pidx_o(x_pidx), .is_pc_o(x_pc));

    rbf_regs #(.DATA_W(DATA_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i && !w_pc),
        .wr_pidx_i  (w_pidx),
        .wr_data_i  (wr_data_i),
        .exc_en_i   (exc_en_i && !x_pc),
        .exc_pidx_i (x_pidx),
        .exc_data_i (exc_ret_i),
        .rd_a_pidx_i(a_pidx),
        .rd_b_pidx_i(b_pidx),
        .rd_a_data_o(a_reg),
        .rd_b_data_o(b_reg)
    );

    rbf_pc #(.DATA_W(DATA_W), .RESET_PC(RESET_PC)) pc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (wr_en_i && w_pc),
        .load_val_i(wr_data_i),
        .step_i    (step_i),
        .pc_o      (pc_q)
    );

    assign pc_read      = pc_q + PC_READ_OFS;
    assign rd_a_data_o  = a_pc ? pc_read : a_reg;
    assign rd_b_data_o  = b_pc ? pc_read : b_reg;
    assign fetch_addr_o = pc_q;

    // R5
    pc_read_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx_i == 4'd15) |-> rd_a_data_o == fetch_addr_o + PC_READ_OFS);

    // R5
    pc_read_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx_i == 4'd15) |-> rd_b_data_o == fetch_addr_o + PC_READ_OFS);

    // R2
    low_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i < 4'd8 && rd_a_idx_i == wr_idx_i)
        |=> (rd_a_idx_i != $past(rd_a_idx_i) || exc_en_i) || rd_a_data_o == $past(wr_data_i)
            || $past(exc_en_i));
endmodule

// File: tb/rbf_banked_regfile_tb_top.sv
module rbf_banked_regfile_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] RST_PC     = 32'h0000_0100;

    localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                           M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                           M_SYS = 5'b11111;

    logic        clk = 0, rst_n = 0;
    logic [4:0]  mode = M_USR, exc_mode = M_USR;
    logic [3:0]  ra = 0, rb = 0, widx = 0;
    logic        wen = 0, step = 0, exc_en = 0;
    logic [31:0] wdata = 0, exc_ret = 0;
    logic [31:0] rda, rdb, fetch;
    int          n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rbf_banked_regfile #(.DATA_W(32), .RESET_PC(RST_PC)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .rd_a_idx_i(ra), .rd_a_data_o(rda), .rd_b_idx_i(rb), .rd_b_data_o(rdb),
        .wr_en_i(wen), .wr_idx_i(widx), .wr_data_i(wdata), .step_i(step),
        .exc_en_i(exc_en), .exc_mode_i(exc_mode), .exc_ret_i(exc_ret),
        .fetch_addr_o(fetch)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] m, input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        mode = m; widx = idx; wdata = d; wen = 1;
        @(negedge clk);
        wen = 0;
    endtask

    task automatic rd(input logic [4:0] m, input logic [3:0] idx, output logic [31:0] d);
        mode = m; ra = idx; rb = idx;
        #1;
        d = rda;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R10 fetch after reset", fetch, RST_PC);
        rd(M_USR, 4'd0, v);  check("R10 r0 zero", v, 32'd0);
        rd(M_SVC, 4'd14, v); check("R10 svc r14 zero", v, 32'd0);
        rd(M_USR, 4'd15, v); check("R5 r15 read after reset", v, RST_PC + 32'd8);
        check("R5 r15 on port B", rdb, RST_PC + 32'd8);
    endtask

    task automatic t_low_shared();
        logic [31:0] v;
        wr(M_IRQ, 4'd3, 32'hA5A5_0003);
        rd(M_USR, 4'd3, v); check("R2 r3 seen in user", v, 32'hA5A5_0003);
        rd(M_FIQ, 4'd3, v); check("R2 r3 seen in fiq", v, 32'hA5A5_0003);
        wr(M_FIQ, 4'd7, 32'h7777_0007);
        rd(M_UND, 4'd7, v); check("R2 r7 seen in und", v, 32'h7777_0007);
    endtask

    task automatic t_fiq_high();
        logic [31:0] v;
        wr(M_USR, 4'd9,  32'h1111_0009);
        wr(M_FIQ, 4'd9,  32'h2222_0009);
        wr(M_FIQ, 4'd12, 32'h2222_000C);
        rd(M_USR, 4'd9, v);  check("R3 user r9 kept", v, 32'h1111_0009);
        rd(M_FIQ, 4'd9, v);  check("R3 fiq r9 private", v, 32'h2222_0009);
        rd(M_IRQ, 4'd9, v);  check("R3 irq r9 shared", v, 32'h1111_0009);
        rd(M_SVC, 4'd12, v); check("R3 svc r12 untouched", v, 32'd0);
    endtask

    task automatic t_sp_lr();
        logic [31:0] v;
        logic [4:0] ms [6] = '{M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND};
        for (int i = 0; i < 6; i++) wr(ms[i], 4'd13, 32'h5000_0000 + 32'(i));
        for (int i = 0; i < 6; i++) begin
            rd(ms[i], 4'd13, v);
            check("R4 banked r13", v, 32'h5000_0000 + 32'(i));
        end
        rd(M_SYS, 4'd13, v); check("R4 system shares user r13", v, 32'h5000_0000);
        wr(M_SYS, 4'd14, 32'h0000_5E14);
        rd(M_USR, 4'd14, v); check("R4 user sees system r14", v, 32'h0000_5E14);
        rd(M_ABT, 4'd14, v); check("R4 abt r14 separate", v, 32'd0);
    endtask

    task automatic t_bad_mode();
        logic [31:0] v;
        rd(5'b00000, 4'd13, v); check("R1 unknown mode reads user r13", v, 32'h5000_0000);
        rd(5'b10110, 4'd9, v);  check("R1 unknown mode reads shared r9", v, 32'h1111_0009);
        wr(5'b11100, 4'd13, 32'hBAD0_0013);
        rd(M_USR, 4'd13, v);    check("R1 unknown-mode write hits user r13", v, 32'hBAD0_0013);
        rd(M_SVC, 4'd13, v);    check("R1 svc r13 unchanged", v, 32'h5000_0003);
    endtask

    task automatic t_pc();
        logic [31:0] base, v;
        @(negedge clk);
        base = fetch;
        step = 1;
        repeat (3) @(negedge clk);
        step = 0;
        check("R7 three steps", fetch, base + 32'd12);
        @(negedge clk);
        check("R7 hold without step", fetch, base + 32'd12);
        step = 1; mode = M_USR; widx = 4'd15; wdata = 32'h0000_2000; wen = 1;
        @(negedge clk);
        wen = 0; step = 0;
        check("R6 r15 write beats step", fetch, 32'h0000_2000);
        rd(M_IRQ, 4'd15, v); check("R5 r15 read after load", v, 32'h0000_2008);
        rd(M_USR, 4'd0, v);  check("R6 r15 write leaves r0", v, 32'd0);
    endtask

    task automatic t_exception();
        logic [31:0] v;
        @(negedge clk);
        exc_en = 1; exc_mode = M_SVC; exc_ret = 32'h0000_3004;
        @(negedge clk);
        exc_en = 0;
        rd(M_SVC, 4'd14, v); check("R8 svc lr loaded", v, 32'h0000_3004);
        rd(M_IRQ, 4'd14, v); check("R8 irq lr untouched", v, 32'd0);
        rd(M_USR, 4'd14, v); check("R8 user lr untouched", v, 32'h0000_5E14);
        @(negedge clk);
        exc_en = 1; exc_mode = M_FIQ; exc_ret = 32'h0000_4444;
        mode = M_FIQ; widx = 4'd14; wdata = 32'hDEAD_0000; wen = 1;
        @(negedge clk);
        exc_en = 0; wen = 0;
        rd(M_FIQ, 4'd14, v); check("R8 exception beats port write", v, 32'h0000_4444);
    endtask

    task automatic t_rdw();
        logic [31:0] v;
        wr(M_USR, 4'd5, 32'h0000_0055);
        @(negedge clk);
        mode = M_USR; ra = 4'd5; widx = 4'd5; wdata = 32'h0000_0066; wen = 1;
        #1;
        check("R9 old value during write", rda, 32'h0000_0055);
        @(negedge clk);
        wen = 0;
        #1;
        check("R9 new value after edge", rda, 32'h0000_0066);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        t_reset();
        t_low_shared();
        t_fiq_high();
        t_sp_lr();
        t_bad_mode();
        t_pc();
        t_exception();
        t_rdw();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule